// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Word Link

This block moves a binary word of parameterised width across a channel that has no request wire. Every bit travels on a pair of rails, a true rail and a false rail, and the only backward signal is one acknowledge. The transmitting half turns a word into rail codes and holds them. The receiving half watches every pair and captures the word only once all pairs carry a code, which is its completion detection. It then raises the acknowledge. The transmitter answers by returning every pair to the empty spacer. The receiver drops the acknowledge only after it has seen every pair empty again, and only then may the next word start.

The model is synchronous: the rails are registered and sampled on a clock. The transmitter's rail outputs and the receiver's rail inputs are separate ports, so the surrounding logic can add a different delay on each bit. The acknowledge is the same: the receiver drives it out and the transmitter takes it back in on its own port.

The transmitter has three states. TX_IDLE has all rails empty and accepts a word when asked and the acknowledge is low; that move goes to TX_DRIVE. TX_DRIVE holds the codes until the acknowledge is high, then empties the rails and goes to TX_RTZ. TX_RTZ waits for the acknowledge to fall and returns to TX_IDLE.

The receiver also has three states. RX_WAIT captures on completion and goes to RX_ACKED. If any pair is illegal it goes to RX_DISCARD instead. RX_ACKED holds the acknowledge until every pair is empty, then returns to RX_WAIT. RX_DISCARD drops the bad word, keeps the acknowledge low, and returns to RX_WAIT once every pair is empty.

Top module: `dr_link`

## Requirements
- R1: One cycle after a word is accepted, the transmitter drives each bit as a rail pair (true,false). Bit value 1 is (1,0) and bit value 0 is (0,1). While no word is held, every pair is (0,0), which means empty.
- R2: The transmitter never drives the pair (1,1) on any bit.
- R3: The receiver captures only when every pair is non-empty and none is (1,1). In the cycle after the last bit completes, rx_valid is high, rx_data holds the true rails and rx_ack is high. A word with only some pairs valid causes no capture.
- R4: The transmitter holds its rail codes unchanged while the acknowledge input is low. In the cycle after it samples the acknowledge high, it drives every pair empty.
- R5: The receiver keeps rx_ack high while any pair is non-empty. It lowers rx_ack in the cycle after it samples every pair empty.
- R6: rx_valid is a single-cycle pulse. Holding a valid word on the rails after a capture gives no second capture until an all-empty spacer has been seen.
- R7: tx_busy is high from the cycle after a word is accepted until the transmitter has seen the acknowledge low again. It is also high whenever the acknowledge input is high. A tx_valid request while tx_busy is high has no effect on the rails.
- R8: If any pair reads (1,1), rx_error is set and stays set until reset. That word is not captured, rx_ack stays low, and nothing is captured until all pairs have been empty.
- R9: A synchronous active-high reset sets every transmitter rail empty and clears rx_ack, rx_valid, rx_error and tx_busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | Request to send tx_data |
| tx_data | input | WIDTH | Word to send |
| tx_busy | output | 1 | Transmitter cannot accept a word |
| tx_rail_t | output | WIDTH | Transmitter true rails |
| tx_rail_f | output | WIDTH | Transmitter false rails |
| tx_ack | input | 1 | Acknowledge as seen by the transmitter |
| rx_rail_t | input | WIDTH | Receiver true rails |
| rx_rail_f | input | WIDTH | Receiver false rails |
| rx_ack | output | 1 | Acknowledge driven by the receiver |
| rx_valid | output | 1 | One-cycle pulse with a captured word |
| rx_data | output | WIDTH | Captured word |
| rx_error | output | 1 | Sticky flag for an illegal rail pair |

## Verification
Completion detection and illegal-code detection can both be triggered in the same receiver cycle: the last missing bits turn valid while another pair reads (1,1). The bench provokes this by driving the receiver rails by hand, with every pair carrying a code and one pair carrying (1,1). It judges the case by rx_error rising while rx_valid and rx_ack stay low. It then checks that repairing the bad pair without a spacer still captures nothing. In the looped runs, every bit of the rails is copied after its own random delay, so the receiver's completion moment lands on different cycles relative to the transmitter.

// File: rtl/dr_link_pkg.sv
package dr_link_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_DRIVE = 2'd1,
        TX_RTZ   = 2'd2
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_WAIT    = 2'd0,
        RX_ACKED   = 2'd1,
        RX_DISCARD = 2'd2
    } rx_state_t;
endpackage

// File: rtl/dr_completion.sv
module dr_completion #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rail_t,
    input  logic [WIDTH-1:0] rail_f,
    output logic             all_valid,
    output logic             all_empty,
    output logic             any_illegal
);
    logic [WIDTH-1:0] pair_full;
    logic [WIDTH-1:0] pair_void;
    logic [WIDTH-1:0] pair_bad;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pair
        assign pair_full[i] = rail_t[i] | rail_f[i];
        assign pair_void[i] = ~(rail_t[i] | rail_f[i]);
        assign pair_bad[i]  = rail_t[i] & rail_f[i];
    end

    assign all_valid   = &pair_full;
    assign all_empty   = &pair_void;
    assign any_illegal = |pair_bad;
endmodule

// File: rtl/dr_tx.sv
module dr_tx
    import dr_link_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    input  logic             ack_in,
    output logic             busy,
    output logic [WIDTH-1:0] rail_t,
    output logic [WIDTH-1:0] rail_f
);
    tx_state_t state_q, state_d;
    logic      accept;

    assign accept = in_valid && (state_q == TX_IDLE) && !ack_in;
    assign busy   = (state_q != TX_IDLE) || ack_in;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (accept) state_d = TX_DRIVE;
            TX_DRIVE: if (ack_in) state_d = TX_RTZ;
            TX_RTZ:   if (!ack_in) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rail_t <= '0;
            rail_f <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (accept) begin
                        rail_t <= in_data;
                        rail_f <= ~in_data;
                    end else begin
                        rail_t <= '0;
                        rail_f <= '0;
                    end
                end
                TX_DRIVE: begin
                    if (ack_in) begin
                        rail_t <= '0;
                        rail_f <= '0;
                    end
                end
                TX_RTZ: begin
                    rail_t <= '0;
                    rail_f <= '0;
                end
                default: begin
                    rail_t <= '0;
                    rail_f <= '0;
                end
            endcase
        end
    end

    a_r2_no_double_rail: assert property (@(posedge clk) disable iff (rst)
        (rail_t & rail_f) == '0);

    a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_DRIVE && !ack_in) |=> ($stable(rail_t) && $stable(rail_f)));

    a_r4_spacer_after_ack: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_DRIVE && ack_in) |=> (rail_t == '0 && rail_f == '0));

    a_r7_no_accept_when_busy: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_IDLE && ack_in) |=> (state_q == TX_IDLE));
endmodule

// File: rtl/dr_rx.sv
module dr_rx
    import dr_link_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] rail_t,
    input  logic [WIDTH-1:0] rail_f,
    output logic             ack,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    output logic             proto_err
);
    rx_state_t state_q, state_d;
    logic      all_valid, all_empty, any_illegal;

    dr_completion #(.WIDTH(WIDTH)) u_detect (
        .rail_t      (rail_t),
        .rail_f      (rail_f),
        .all_valid   (all_valid),
        .all_empty   (all_empty),
        .any_illegal (any_illegal)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_WAIT: begin
                if (any_illegal)    state_d = RX_DISCARD;
                else if (all_valid) state_d = RX_ACKED;
            end
            RX_ACKED:   if (all_empty) state_d = RX_WAIT;
            RX_DISCARD: if (all_empty) state_d = RX_WAIT;
            default:    state_d = RX_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RX_WAIT;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack       <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            proto_err <= 1'b0;
        end else begin
            ack       <= (state_d == RX_ACKED);
            out_valid <= 1'b0;
            if (any_illegal) proto_err <= 1'b1;
            if (state_q == RX_WAIT && state_d == RX_ACKED) begin
                out_valid <= 1'b1;
                out_data  <= rail_t;
            end
        end
    end

    a_r3_ack_on_completion: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(all_valid && !any_illegal));

    a_r5_ack_falls_on_spacer: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> $past(all_empty));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r8_error_sticky: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    a_r8_no_capture_on_bad: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_WAIT && any_illegal) |=> (!ack && !out_valid));
endmodule

// File: rtl/dr_link.sv
module dr_link #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_valid,
    input  logic [WIDTH-1:0] tx_data,
    output logic             tx_busy,
    output logic [WIDTH-1:0] tx_rail_t,
    output logic [WIDTH-1:0] tx_rail_f,
    input  logic             tx_ack,
    input  logic [WIDTH-1:0] rx_rail_t,
    input  logic [WIDTH-1:0] rx_rail_f,
    output logic             rx_ack,
    output logic             rx_valid,
    output logic [WIDTH-1:0] rx_data,
    output logic             rx_error
);
    dr_tx #(.WIDTH(WIDTH)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (tx_valid),
        .in_data  (tx_data),
        .ack_in   (tx_ack),
        .busy     (tx_busy),
        .rail_t   (tx_rail_t),
        .rail_f   (tx_rail_f)
    );

    dr_rx #(.WIDTH(WIDTH)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .rail_t    (rx_rail_t),
        .rail_f    (rx_rail_f),
        .ack       (rx_ack),
        .out_valid (rx_valid),
        .out_data  (rx_data),
        .proto_err (rx_error)
    );
endmodule

// File: tb/tb_dr_link.sv
`timescale 1ns/1ps
module tb_dr_link;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tx_valid = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         tx_busy;
    logic [W-1:0] tx_rail_t, tx_rail_f;
    logic [W-1:0] rx_rail_t, rx_rail_f;
    logic         rx_ack, rx_valid, rx_error;
    logic [W-1:0] rx_data;

    logic         loop_en = 1'b0;
    logic [W-1:0] loop_t = '0, loop_f = '0;
    logic [W-1:0] man_t = '0, man_f = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    assign rx_rail_t = loop_en ? loop_t : man_t;
    assign rx_rail_f = loop_en ? loop_f : man_f;

    dr_link #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_busy(tx_busy),
        .tx_rail_t(tx_rail_t), .tx_rail_f(tx_rail_f), .tx_ack(rx_ack),
        .rx_rail_t(rx_rail_t), .rx_rail_f(rx_rail_f),
        .rx_ack(rx_ack), .rx_valid(rx_valid), .rx_data(rx_data), .rx_error(rx_error)
    );

    // Each bit pair follows the transmitter after its own random delay
    always @(negedge clk) begin
        for (int i = 0; i < W; i++) begin
            if ({loop_t[i], loop_f[i]} != {tx_rail_t[i], tx_rail_f[i]} && $urandom_range(3) == 0) begin
                loop_t[i] <= tx_rail_t[i];
                loop_f[i] <= tx_rail_f[i];
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        check(tx_rail_t == '0 && tx_rail_f == '0, "R9 rails empty", {tx_rail_t, tx_rail_f}, 64'h0);
        check(!rx_ack && !rx_valid && !rx_error && !tx_busy, "R9 flags clear",
              {60'h0, rx_ack, rx_valid, rx_error, tx_busy}, 64'h0);
    endtask

    task automatic t_send(input logic [W-1:0] d);
        int n;
        loop_en  = 1'b1;
        tx_valid = 1'b1;
        tx_data  = d;
        tick();
        tx_valid = 1'b0;
        check(tx_rail_t == d && tx_rail_f == ~d, "R1 rail encoding", {tx_rail_t, tx_rail_f}, {d, ~d});
        check(tx_busy == 1'b1, "R7 busy after accept", 64'(tx_busy), 64'h1);
        n = 0;
        while (!rx_valid && n < 300) begin tick(); n++; end
        check(rx_valid && rx_data == d, "R3 captured word", 64'(rx_data), 64'(d));
        check(rx_ack == 1'b1, "R3 ack with capture", 64'(rx_ack), 64'h1);
        tick();
        check(tx_rail_t == '0 && tx_rail_f == '0, "R4 spacer after ack", {tx_rail_t, tx_rail_f}, 64'h0);
        check(!rx_valid, "R6 single pulse", 64'(rx_valid), 64'h0);
        n = 0;
        while (tx_busy && n < 300) begin tick(); n++; end
        check(!tx_busy && !rx_ack, "R5 handshake closed", {62'h0, tx_busy, rx_ack}, 64'h0);
    endtask

    task automatic t_partial_and_hold();
        logic [W-1:0] w;
        w = 32'h1234_5678;
        loop_en = 1'b0;
        man_t = w & 32'h0000_FFFF;
        man_f = ~w & 32'h0000_FFFF;
        tick(); tick(); tick();
        check(!rx_valid && !rx_ack, "R3 partial word ignored", {62'h0, rx_valid, rx_ack}, 64'h0);
        man_t = w;
        man_f = ~w;
        tick();
        check(rx_valid && rx_data == w && rx_ack, "R3 capture on completion", 64'(rx_data), 64'(w));
        tick(); tick(); tick();
        check(!rx_valid && rx_ack, "R6 no recapture while held", {62'h0, rx_valid, rx_ack}, 64'h1);
        man_t = w & 32'hFFFF_0000;
        man_f = ~w & 32'hFFFF_0000;
        tick(); tick();
        check(rx_ack, "R5 ack held on partial spacer", 64'(rx_ack), 64'h1);
        man_t = '0;
        man_f = '0;
        tick();
        check(!rx_ack, "R5 ack drops on full spacer", 64'(rx_ack), 64'h0);
    endtask

    task automatic t_illegal();
        logic [W-1:0] w;
        w = 32'hCAFE_F00D;
        loop_en = 1'b0;
        man_t = w | 32'h0000_0020;
        man_f = ~w | 32'h0000_0020;
        tick();
        check(rx_error && !rx_valid && !rx_ack, "R8 illegal pair with completion",
              {61'h0, rx_error, rx_valid, rx_ack}, 64'h4);
        man_t = w;
        man_f = ~w;
        tick(); tick();
        check(!rx_valid && !rx_ack, "R8 no capture before spacer", {62'h0, rx_valid, rx_ack}, 64'h0);
        man_t = '0;
        man_f = '0;
        tick();
        man_t = w;
        man_f = ~w;
        tick();
        check(rx_valid && rx_data == w, "R8 capture resumes after spacer", 64'(rx_data), 64'(w));
        check(rx_error, "R8 error stays set", 64'(rx_error), 64'h1);
        man_t = '0;
        man_f = '0;
        tick();
        check(!rx_ack, "R5 ack drop after recovery", 64'(rx_ack), 64'h0);
    endtask

    task automatic t_busy_ignore();
        int n;
        logic [W-1:0] a, b;
        a = 32'h0F0F_33CC;
        b = 32'hFFFF_0000;
        loop_en = 1'b0;
        man_t = '0;
        man_f = '0;
        tx_valid = 1'b1;
        tx_data  = a;
        tick();
        tx_data = b;
        tick(); tick();
        check(tx_rail_t == a && tx_rail_f == ~a, "R4 hold without ack", {tx_rail_t, tx_rail_f}, {a, ~a});
        check(tx_busy, "R7 busy while waiting", 64'(tx_busy), 64'h1);
        tx_valid = 1'b0;
        loop_en  = 1'b1;
        n = 0;
        while (!rx_valid && n < 300) begin tick(); n++; end
        check(rx_data == a, "R7 second request ignored", 64'(rx_data), 64'(a));
        n = 0;
        while (tx_busy && n < 300) begin tick(); n++; end
        tick();
        check(tx_rail_t == '0 && tx_rail_f == '0, "R7 nothing queued", {tx_rail_t, tx_rail_f}, 64'h0);
    endtask

    initial begin
        t_reset();
        t_send(32'h0000_0000);
        t_send(32'hFFFF_FFFF);
        t_send(32'hA5A5_5A5A);
        t_send(32'h8000_0001);
        t_partial_and_hold();
        t_illegal();
        t_busy_ignore();
        t_send(32'h1357_9BDF);
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule